// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Serial Bus

This block is the control port of an audio processor. It sits on a standard I2C bus as a slave, sampled by a fast system clock. It holds ten 8-bit control registers: source select, loudness, volume, tone, four speaker attenuators, input gain with mid tone, and mute. A bus master writes a chip address, then a subaddress byte, then any number of data bytes. The subaddress byte carries a 4-bit register index and a flag that moves the index on after each byte. With the flag clear, every data byte lands in the same register, so a host can ramp one setting without sending the address again. In read mode the block returns a one-byte status word made of four status pins. It sends that byte again, sampled fresh, each time the master acknowledges.

Each accepted write shows up on the register outputs. It also appears as a one-cycle write beat on `wr_valid_o`, with its index and data. That beat has no ready input: the bus cannot be held off, because clock stretching is not provided, so a consumer must take every beat in the cycle it appears. The block follows a strict framing rule. Once a transfer has started, only a STOP ends it. A START seen while the bus is still owned is ignored.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: The slave answers only the address byte whose upper seven bits are 1000_10 followed by `addr_strap_i`, with bit 0 as direction (0 write, 1 read). For any other address it gives no ACK, and it writes nothing and drives nothing until the next STOP.
- R2: In the subaddress byte, bits 3:0 are the register index and bit 4 is the advance flag. Bits 7:5 have no effect.
- R3: With the advance flag set, the index goes up by one after every data byte and wraps from 15 to 0. A byte aimed at index 10 to 15 is acknowledged but changes no register and raises no write beat.
- R4: With the advance flag clear, every data byte of the transfer is written to the same register, and the last byte stays.
- R5: A START is honoured only when the bus is free, which means after reset or a STOP. A START inside an active transfer does not restart the address phase.
- R6: In the write direction, each byte of an addressed transfer is taken MSB first. It is acknowledged by pulling SDA low through the ninth clock. SDA changes only while SCL is low.
- R7: In read mode the slave sends {4'b0000, stereo, soft_mute, zc_mute, pause_n} MSB first, sampled when the byte is loaded. After a master ACK it sends a fresh copy. After a master NACK it leaves SDA released until STOP.
- R8: Reset clears all registers to 0x00, releases SDA and holds `wr_valid_o` low.
- R9: A write raises `wr_valid_o` for exactly one cycle with `wr_idx_o` and `wr_data_o`. The addressed register shows the data on the next cycle. The registers do not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_strap_i | input | 1 | Strap that sets address bit 1 |
| pause_n_i | input | 1 | Pause detector, low when a pause is seen |
| zc_mute_i | input | 1 | Zero-cross mute engaged |
| soft_mute_i | input | 1 | Soft mute engaged |
| stereo_i | input | 1 | Stereo signal detected |
| regs_o | output | NUM_REGS*DATA_W | Register file, register k at bits k*8 +: 8 |
| wr_valid_o | output | 1 | One-cycle write beat (no back-pressure) |
| wr_idx_o | output | 4 | Index of the register being written |
| wr_data_o | output | DATA_W | Byte being written |

## Verification
The assertions assume the bus is sampled well above its bit rate. Each SCL high or low phase must last at least three system clocks, so the two-flop synchroniser has settled before the slave moves SDA. The assertions also assume the master never changes SDA while SCL is high, except to make a START or STOP. The bench drives every bus phase for five clocks, so each bit takes twenty clocks. It changes its data only a quarter period after SCL falls, and it models the line as a wired AND of master and slave.

// File: rtl/audio_i2c_pkg.sv
package audio_i2c_pkg;
  localparam int IDX_W = 4;                    // index counter is modulo 16
  localparam logic [5:0] DEV_ID_HI = 6'b100010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  function automatic logic [7:0] pack_status(input logic st, input logic sm,
                                             input logic zm, input logic p_n);
    return {4'b0000, st, sm, zm, p_n};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '1;
    else        line_q <= line_s;
  end

  assign scl_s     = line_s[0];
  assign sda_s     = line_s[1];
  assign scl_rise  = line_s[0] & ~line_q[0];
  assign scl_fall  = ~line_s[0] & line_q[0];
  assign start_det = line_s[0] & line_q[0] & line_q[1] & ~line_s[1];
  assign stop_det  = line_s[0] & line_q[0] & ~line_q[1] & line_s[1];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import audio_i2c_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              strap,
  input  logic [7:0]        status,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  phase_t           phase;
  logic             busy;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_byte;
  logic             ack_q;
  logic             rd_mode;
  logic             auto_inc;
  logic             mack_q;
  logic [IDX_W-1:0] idx_q;

  assign rx_byte = {rx_sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      busy     <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ack_q    <= 1'b0;
      rd_mode  <= 1'b0;
      auto_inc <= 1'b0;
      mack_q   <= 1'b0;
      idx_q    <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (stop_det) begin
        busy    <= 1'b0;
        phase   <= PH_IDLE;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
      end else if (start_det && !busy) begin
        busy    <= 1'b1;
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (scl_rise) begin
        if (phase inside {PH_ADDR, PH_SUB, PH_WDATA, PH_RDATA}) begin
          if (bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
            rx_sh   <= rx_byte;
            if (bit_cnt == 4'd7) begin
              case (phase)
                PH_ADDR: begin
                  ack_q   <= (rx_byte[7:1] == {DEV_ID_HI, strap});
                  rd_mode <= rx_byte[0];
                end
                PH_SUB: begin
                  ack_q    <= 1'b1;
                  auto_inc <= rx_byte[4];
                  idx_q    <= rx_byte[3:0];
                end
                PH_WDATA: begin
                  ack_q <= 1'b1;
                  if (32'(idx_q) < NUM_REGS) begin
                    wr_valid <= 1'b1;
                    wr_idx   <= idx_q;
                    wr_data  <= DATA_W'(rx_byte);
                  end
                  if (auto_inc) idx_q <= idx_q + 1'b1;
                end
                default: ;
              endcase
            end
          end else if (bit_cnt == 4'd8) begin
            bit_cnt <= 4'd9;
            mack_q  <= !sda_s;
          end
        end
      end else if (scl_fall) begin
        if (phase == PH_RDATA) begin
          if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= !tx_sh[6];
          end else if (bit_cnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            if (mack_q) begin
              tx_sh  <= status;
              sda_oe <= !status[7];
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_SKIP;
            end
          end
        end else if (phase inside {PH_ADDR, PH_SUB, PH_WDATA}) begin
          if (bit_cnt == 4'd8) begin
            sda_oe <= ack_q;
          end else if (bit_cnt == 4'd9) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            case (phase)
              PH_ADDR: begin
                if (!ack_q) begin
                  phase <= PH_SKIP;
                end else if (rd_mode) begin
                  phase  <= PH_RDATA;
                  tx_sh  <= status;
                  sda_oe <= !status[7];
                end else begin
                  phase <= PH_SUB;
                end
              end
              PH_SUB:  phase <= PH_WDATA;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import audio_i2c_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  val <= '0;
      else if (wr_valid && 32'(wr_idx) == k)       val <= wr_data;
    end
    assign regs_flat[k*DATA_W +: DATA_W] = val;
  end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_i2c_pkg::*;
#(
  parameter int NUM_REGS    = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  input  logic                       addr_strap_i,
  input  logic                       pause_n_i,
  input  logic                       zc_mute_i,
  input  logic                       soft_mute_i,
  input  logic                       stereo_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       wr_valid_o,
  output logic [IDX_W-1:0]           wr_idx_o,
  output logic [DATA_W-1:0]          wr_data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] status;

  assign status = pack_status(stereo_i, soft_mute_i, zc_mute_i, pause_n_i);

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap_i), .status(status),
    .sda_oe(sda_pull_o), .wr_valid(wr_valid_o),
    .wr_idx(wr_idx_o), .wr_data(wr_data_o)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid_o),
    .wr_idx(wr_idx_o), .wr_data(wr_data_o), .regs_flat(regs_o)
  );

  logic unused_scl_s;
  assign unused_scl_s = scl_s;
endmodule

// File: rtl/audio_ctl_i2c_checker.sv
module audio_ctl_i2c_checker
  import audio_i2c_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_i,
  input logic                       sda_pull_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic                       wr_valid_o,
  input logic [IDX_W-1:0]           wr_idx_o,
  input logic [DATA_W-1:0]          wr_data_o
);
  logic              v_d;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] landed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_d <= 1'b0; idx_d <= '0; data_d <= '0;
    end else begin
      v_d <= wr_valid_o; idx_d <= wr_idx_o; data_d <= wr_data_o;
    end
  end

  always_comb begin
    landed = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (32'(idx_d) == k) landed = regs_o[k*DATA_W +: DATA_W];
  end

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    v_d |-> landed == data_d);

  p_hold_between_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_o |=> $stable(regs_o));

  p_real_index_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> 32'(wr_idx_o) < NUM_REGS);

  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/audio_ctl_i2c_slave_tb_top.sv
module audio_ctl_i2c_slave_tb_top;
  localparam int NR = 10;
  localparam int Q  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic strap = 1'b0;
  logic pause_n = 1'b1, zcm = 1'b0, smu = 1'b0, ster = 1'b0;
  logic sda_pull, wr_valid;
  logic [NR*8-1:0] regs;
  logic [3:0] wr_idx;
  logic [7:0] wr_data;
  wire sda_line = m_sda & ~sda_pull;

  int checks = 0, failures = 0, strobes = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];

  always #5 clk = ~clk;

  audio_ctl_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_strap_i(strap),
    .pause_n_i(pause_n), .zc_mute_i(zcm), .soft_mute_i(smu), .stereo_i(ster),
    .regs_o(regs), .wr_valid_o(wr_valid), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  always @(negedge clk) if (wr_valid) strobes++;

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1; hold(Q); m_scl = 1; hold(Q); m_sda = 0; hold(Q); m_scl = 0; hold(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; hold(Q); m_scl = 1; hold(Q); m_sda = 1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(Q); m_scl = 1; hold(2*Q); m_scl = 0; hold(Q);
    end
    m_sda = 1; hold(Q); m_scl = 1; hold(Q);
    acked = !sda_line;
    hold(Q); m_scl = 0; hold(Q);
  endtask

  task automatic read_bits(output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); m_scl = 1; hold(Q); b[i] = sda_line; hold(Q); m_scl = 0;
    end
  endtask

  task automatic master_ack(input bit ack);
    m_sda = !ack; hold(Q); m_scl = 1; hold(2*Q); m_scl = 0; hold(Q); m_sda = 1;
  endtask

  function automatic logic [7:0] dev_addr(bit good, bit rd);
    return {6'b100010, strap ^ !good, rd};
  endfunction

  task automatic check_regs(string rq);
    for (int k = 0; k < NR; k++) check(rq, regs[k*8 +: 8], exp_r[k]);
  endtask

  // Write transfer with model update; data bytes come from db
  task automatic xfer_write(bit good, logic [7:0] sub, int n, logic [7:0] db[16], string rq);
    bit a;
    int base = strobes, exp_cnt = 0;
    logic [3:0] idx = sub[3:0];
    bus_start();
    send_byte(dev_addr(good, 0), a); check({rq, " R1 addr ack"}, a, good);
    send_byte(sub, a);               check({rq, " R6 sub ack"}, a, good);
    for (int i = 0; i < n; i++) begin
      send_byte(db[i], a);           check({rq, " R6 data ack"}, a, good);
      if (good) begin
        if (idx < NR) begin exp_r[idx] = db[i]; exp_cnt++; end
        if (sub[4]) idx = idx + 1;
      end
    end
    bus_stop(); hold(4);
    check_regs({rq, " R9 regs"});
    check({rq, " R3 strobes"}, strobes - base, exp_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] db [16];
    logic [7:0] rb;
    bit a;
    void'($urandom(32'd2024));
    for (int k = 0; k < NR; k++) exp_r[k] = 8'h00;
    hold(4);
    check("R8 sda released in reset", sda_pull, 0);
    rst_n = 1; hold(4);
    check_regs("R8 reset value");
    check("R8 no write beat", wr_valid, 0);

    // R3: advance from 8 through the unused indices and wrap to 0
    for (int i = 0; i < 9; i++) db[i] = 8'hA0 + 8'(i);
    xfer_write(1, 8'h18, 9, db, "R3 wrap");

    // R2 + R4: high bits set, flag clear, three bytes into index 2
    db[0] = 8'h11; db[1] = 8'h22; db[2] = 8'h33;
    xfer_write(1, 8'hE2, 3, db, "R2 R4 same reg");
    check("R4 last byte kept", regs[2*8 +: 8], 8'h33);

    // R1: the other strap value is not answered
    db[0] = 8'h5A; db[1] = 8'hC3;
    xfer_write(0, 8'h13, 2, db, "R1 foreign addr");

    // Full ten-register refresh, strap set
    strap = 1;
    for (int i = 0; i < 10; i++) db[i] = 8'(8'h30 + 8'(i * 7));
    xfer_write(1, 8'h10, 10, db, "R3 full refresh");

    // R5: START while a foreign transfer is still open is ignored
    bus_start();
    send_byte(dev_addr(0, 0), a); check("R5 foreign nack", a, 0);
    bus_start();
    send_byte(dev_addr(1, 0), a); check("R5 restart not honoured", a, 0);
    send_byte(8'h02, a);          check("R5 sub ignored", a, 0);
    send_byte(8'hEE, a);          check("R5 data ignored", a, 0);
    bus_stop(); hold(4);
    check_regs("R5 regs unchanged");

    // R7: read status twice then NACK
    ster = 1; smu = 0; zcm = 1; pause_n = 0;
    bus_start();
    send_byte(dev_addr(1, 1), a); check("R7 read addr ack", a, 1);
    read_bits(rb); check("R7 first status", rb, 8'h0A);
    ster = 0; smu = 1; zcm = 0; pause_n = 1;
    master_ack(1);
    read_bits(rb); check("R7 fresh status", rb, 8'h05);
    master_ack(0);
    read_bits(rb); check("R7 silent after nack", rb, 8'hFF);
    bus_stop(); hold(4);
    check_regs("R7 regs unchanged by read");

    // Constrained random write transfers
    for (int t = 0; t < 25; t++) begin
      bit good;
      logic [7:0] sub;
      int n;
      strap = 1'($urandom_range(0, 1));
      good  = ($urandom_range(0, 9) != 0);
      sub   = {3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15))};
      n     = $urandom_range(1, 6);
      for (int i = 0; i < n; i++) db[i] = 8'($urandom);
      xfer_write(good, sub, n, db, "R9 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule